// File: doc/BRIEF.md
# Pushbutton Tone Generator

This block drives a one-bit speaker line with a square wave whose pitch is picked by two pushbuttons. Pressing the right button alone, the left button alone, or both together selects one of three tones. Each tone's frequency is 500 Hz plus 100 Hz times a decimal digit parameter. The clock rate is a parameter, 50 MHz by default.

Both buttons pass through a synchroniser, and then a registered selector. The selector produces an "any button" flag and the half-period reload value for the chosen tone. A down-counter then times each half period. Each time the counter reaches zero, it reloads and the speaker line flips. While no button is held, the counter is parked at 1 and the speaker line keeps its level. Pressing a button therefore gives a fixed, short delay before the first edge. Changing the button combination while a tone plays takes effect at the next reload, with no reset needed.

Top module: `tone_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `spk` becomes 0 and the divider count is set to 1; `spk` reads 0 after reset.
- R2: With only `btn_right` held (button code 01, bit 0 = right, bit 1 = left), `spk` toggles every N cycles, where N = CLK_HZ / (2·(500 + 100·DIGIT_RIGHT)) using integer division.
- R3: With only `btn_left` held (code 10), `spk` toggles every N = CLK_HZ / (2·(500 + 100·DIGIT_LEFT)) cycles.
- R4: With both buttons held (code 11), `spk` toggles every N = CLK_HZ / (2·(500 + 100·DIGIT_BOTH)) cycles.
- R5: With no button held (code 00), `spk` holds its last value, whether 0 or 1, and does not toggle.
- R6: From an idle state, the first `spk` toggle happens on the (SYNC_STAGES + 2)-th rising edge after the edge that first samples a pressed button.
- R7: When the button combination changes from one held code to another, the toggle interval reaches the new tone's N within two toggles, with no reset.
- R8: The divider count never exceeds the largest reload value, and it decrements by exactly one per cycle between reloads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_right | input | 1 | Right pushbutton, asynchronous, high when pressed |
| btn_left | input | 1 | Left pushbutton, asynchronous, high when pressed |
| spk | output | 1 | Registered square-wave speaker drive |

## Verification
The hardest case to reach from the ports is a release while the speaker is high. Only then can the bench tell "holds its last value" apart from "returns to 0". A release also has to avoid the in-flight toggle that the synchroniser and selector delay can still let through. To get there, the bench releases the buttons on the cycle right after it sees a toggle. Because every half period is longer than the pipeline delay, the level just observed is the one that must persist, and the bench repeats this after odd and even toggle counts so both levels are covered. It also steps through all ordered pairs of the three held codes to reach mid-tone switches.

// File: rtl/tone_pkg.sv
package tone_pkg;

  // Button code: bit 0 = right, bit 1 = left
  typedef enum logic [1:0] {
    SEL_IDLE  = 2'b00,
    SEL_RIGHT = 2'b01,
    SEL_LEFT  = 2'b10,
    SEL_BOTH  = 2'b11
  } tone_sel_e;

  localparam int unsigned BASE_HZ = 500;
  localparam int unsigned STEP_HZ = 100;

  // Clock cycles in half a period of the tone chosen by digit
  function automatic int unsigned half_cycles(int unsigned clk_hz, int unsigned digit);
    return clk_hz / (2 * (BASE_HZ + STEP_HZ * digit));
  endfunction

endpackage

// File: rtl/tone_sync.sv
module tone_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/tone_select.sv
module tone_select
  import tone_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned DIGIT_RIGHT = 0,
  parameter int unsigned DIGIT_LEFT  = 1,
  parameter int unsigned DIGIT_BOTH  = 2,
  parameter int          CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       btn_s,
  output logic             active_q,
  output logic [CNT_W-1:0] reload_q
);

  localparam logic [CNT_W-1:0] RLD_RIGHT = CNT_W'(half_cycles(CLK_HZ, DIGIT_RIGHT) - 1);
  localparam logic [CNT_W-1:0] RLD_LEFT  = CNT_W'(half_cycles(CLK_HZ, DIGIT_LEFT)  - 1);
  localparam logic [CNT_W-1:0] RLD_BOTH  = CNT_W'(half_cycles(CLK_HZ, DIGIT_BOTH)  - 1);

  tone_sel_e        sel;
  logic [CNT_W-1:0] reload_d;

  assign sel = tone_sel_e'(btn_s);

  always_comb begin
    unique case (sel)
      SEL_RIGHT: reload_d = RLD_RIGHT;
      SEL_LEFT:  reload_d = RLD_LEFT;
      SEL_BOTH:  reload_d = RLD_BOTH;
      default:   reload_d = reload_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      reload_q <= RLD_RIGHT;
    end else begin
      active_q <= (sel != SEL_IDLE);
      reload_q <= reload_d;
    end
  end

endmodule

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             spk_q
);

  localparam logic [CNT_W-1:0] PARK = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= PARK;
      spk_q <= 1'b0;
    end else if (!active) begin
      cnt_q <= PARK;
    end else if (cnt_q == '0) begin
      cnt_q <= reload;
      spk_q <= ~spk_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/tone_gen.sv
module tone_gen
  import tone_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned DIGIT_RIGHT = 0,
  parameter int unsigned DIGIT_LEFT  = 1,
  parameter int unsigned DIGIT_BOTH  = 2,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_right,
  input  logic btn_left,
  output logic spk
);

  localparam int unsigned MAX_HALF = half_cycles(CLK_HZ, 0);
  localparam int          CNT_W    = (MAX_HALF < 2) ? 2 : $clog2(MAX_HALF + 1);

  logic [1:0]       btn_s;
  logic             act_q;
  logic [CNT_W-1:0] rld_q;
  logic [CNT_W-1:0] cnt_q;

  tone_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din({btn_left, btn_right}), .dout(btn_s)
  );

  tone_select #(
    .CLK_HZ(CLK_HZ), .DIGIT_RIGHT(DIGIT_RIGHT), .DIGIT_LEFT(DIGIT_LEFT),
    .DIGIT_BOTH(DIGIT_BOTH), .CNT_W(CNT_W)
  ) u_sel (
    .clk(clk), .rst(rst), .btn_s(btn_s), .active_q(act_q), .reload_q(rld_q)
  );

  tone_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst(rst), .active(act_q), .reload(rld_q), .cnt_q(cnt_q), .spk_q(spk)
  );

endmodule

// File: rtl/tone_gen_chk.sv
module tone_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             active,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] cnt,
  input logic             spk
);

  AST_IDLE_PARK: assert property (@(posedge clk) disable iff (rst)
    !active |=> (cnt == CNT_W'(1)) && $stable(spk)); // R5

  AST_ZERO_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (active && cnt == '0) |=> (spk != $past(spk))); // R2

  AST_NO_EARLY_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> $stable(spk)); // R3

  AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (active && cnt == '0) |=> (cnt == $past(reload))); // R7

  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (active && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R8

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (cnt == CNT_W'(1)) && !spk); // R1

endmodule

bind tone_gen tone_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .active(act_q), .reload(rld_q), .cnt(cnt_q), .spk(spk)
);

// File: tb/tone_gen_bench.sv
module tone_gen_bench;

  localparam int unsigned CLK_HZ = 20_000;
  localparam int unsigned D_R    = 3;
  localparam int unsigned D_L    = 0;
  localparam int unsigned D_B    = 9;
  localparam int          SYNC   = 2;
  localparam int          WD_MAX = 150_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_r = 1'b0;
  logic btn_l = 1'b0;
  logic spk;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  tone_gen #(
    .CLK_HZ(CLK_HZ), .DIGIT_RIGHT(D_R), .DIGIT_LEFT(D_L),
    .DIGIT_BOTH(D_B), .SYNC_STAGES(SYNC)
  ) u_tone_gen (
    .clk(clk), .rst(rst), .btn_right(btn_r), .btn_left(btn_l), .spk(spk)
  );

  function automatic int exp_half(int code);
    int d;
    d = (code == 1) ? D_R : (code == 2) ? D_L : D_B;
    return CLK_HZ / (2 * (500 + 100 * d));
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_code(int code);
    @(negedge clk);
    btn_r = code[0];
    btn_l = code[1];
  endtask

  // negedges until spk changes; called at a negedge
  task automatic wait_toggle(output int n);
    logic prev;
    prev = spk;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (spk == prev && n < 1000);
  endtask

  task automatic tone_req(int code, output string req);
    req = (code == 1) ? "R2" : (code == 2) ? "R3" : "R4";
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WD_MAX) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD_MAX);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n;
    string rq;
    logic held;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 spk after reset", spk, 0);

    // R6 latency from idle, then R2/R3/R4 steady intervals
    for (int code = 1; code < 4; code++) begin
      @(negedge clk);
      btn_r = code[0];
      btn_l = code[1];
      wait_toggle(n);
      check("R6 first toggle latency", n, SYNC + 3);
      tone_req(code, rq);
      for (int k = 0; k < 6; k++) begin
        wait_toggle(n);
        check(rq, n, exp_half(code));
      end
      // R5: release right after a toggle; hold the level just seen
      wait_toggle(n);
      held = spk;
      btn_r = 1'b0;
      btn_l = 1'b0;
      for (int k = 0; k < 120; k++) begin
        @(negedge clk);
        if (spk != held) break;
      end
      check("R5 idle hold", spk, held);
    end

    // R5 with the opposite level: one extra toggle before release
    for (int lvl = 0; lvl < 2; lvl++) begin
      set_code(1);
      wait_toggle(n);
      if (spk != lvl[0]) wait_toggle(n);
      held = spk;
      btn_r = 1'b0;
      btn_l = 1'b0;
      repeat (100) @(negedge clk);
      check("R5 idle hold level", spk, held);
    end

    // R7: all ordered pairs of held codes, switched mid-tone
    for (int a = 1; a < 4; a++) begin
      for (int b = 1; b < 4; b++) begin
        if (a == b) continue;
        set_code(a);
        wait_toggle(n);
        wait_toggle(n);
        repeat (3) @(negedge clk);
        btn_r = b[0];
        btn_l = b[1];
        wait_toggle(n);
        wait_toggle(n);
        wait_toggle(n);
        check("R7 switched interval", n, exp_half(b));
        wait_toggle(n);
        check("R7 switched interval", n, exp_half(b));
      end
    end

    // R1 again: reset mid-tone clears spk
    set_code(3);
    wait_toggle(n);
    if (spk == 1'b0) wait_toggle(n);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    btn_r = 1'b0;
    btn_l = 1'b0;
    check("R1 spk after mid-tone reset", spk, 0);
    repeat (8) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule